// File: doc/BRIEF.md
# Warp Issue Scheduler

This block chooses, every clock cycle, at most one warp to issue from the warps resident in a streaming core. Each warp has a 32-thread width, and the threads of a block map onto warps by consecutive thread IDs. Warp 0 of a block holds threads 0 to 31. Warps of block `b` therefore hold the warp indices `b*WARPS_PER_BLOCK` to `b*WARPS_PER_BLOCK + WARPS_PER_BLOCK - 1`. With the default parameters there are 24 resident slots arranged as three blocks of eight warps, which matches three blocks of 256 threads.

A warp can be chosen only when it is resident and its ready flag says the operands of its next instruction are available. Among the eligible warps the one with the largest priority value wins. Ties rotate round-robin, starting from the warp after the one granted last. The scheduler can move to a different warp on every cycle with no bubble. A grant names a single warp, and all threads of that warp then execute the same instruction.

Whole blocks become resident through a launch pulse. Warps leave one at a time through a retire port. When the last warp of a block leaves, the block reports completion with a single-cycle pulse.

Top module: `warp_issue_sched`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `grant_valid` and `block_done` are 0 and no warp is resident. The round-robin pointer resets so that warp 0 is the first candidate.
- R2: A 1 on bit `b` of `launch_mask` makes warps `b*WARPS_PER_BLOCK` to `b*WARPS_PER_BLOCK+WARPS_PER_BLOCK-1` resident from the next cycle on. Those warps are not candidates in the launch cycle itself.
- R3: A warp is eligible in a cycle only if it is resident, its bit in `warp_ready` is 1, and it is not being retired in that cycle. A warp that is not eligible is never granted, whatever its ready flag or priority.
- R4: The grant is registered. `grant_valid` and `grant_warp` seen after a clock edge reflect the inputs of the cycle before that edge. An eligible warp always produces a grant, so consecutive cycles can issue different warps with no idle cycle between them.
- R5: The grant goes to an eligible warp with the largest unsigned priority value. Warp `w` takes its priority from `warp_prio[w*PRIO_W +: PRIO_W]`.
- R6: Among eligible warps that share the largest priority, the grant goes to the first one found by scanning upward from the previously granted warp plus one, wrapping from `NUM_WARPS-1` to 0.
- R7: When no warp is eligible, `grant_valid` is 0 for that cycle and the round-robin pointer keeps its value.
- R8: `retire_valid` with `retire_warp` removes that warp from the resident set for good. Retiring a warp that is not resident changes nothing.
- R9: `block_done[b]` is 1 for exactly one cycle, right after the edge at which a retire empties block `b`. It stays 0 for retires that leave warps of the block resident, and for retires of warps that are not resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_mask | input | NUM_BLOCKS | One bit per block; makes all warps of the block resident |
| retire_valid | input | 1 | Retire request valid |
| retire_warp | input | WID_W | Index of the warp to retire |
| warp_ready | input | NUM_WARPS | Per-warp flag: operands of the next instruction are available |
| warp_prio | input | NUM_WARPS*PRIO_W | Per-warp priority, packed with warp `w` at bits `w*PRIO_W +: PRIO_W` |
| grant_valid | output | 1 | A warp is granted this cycle |
| grant_warp | output | WID_W | Index of the granted warp |
| block_done | output | NUM_BLOCKS | One-cycle pulse when a block's last warp retires |

## Verification
The bound checker compares every grant against a registered copy of the eligible set and the priorities. On every cycle it confirms four things: the granted warp was eligible, its priority was the largest among eligible warps, a grant appears exactly when the eligible set is non-empty, and a completion pulse never coincides with a block that still has resident warps. The exact rotation order among equal-priority warps cannot be seen from those per-cycle properties; the bench's scenarios show it with expected sequences. The same holds for the warp-to-block mapping at launch, the exclusion of a warp in the very cycle it retires, and the absence of effects from retiring an absent warp.

// File: rtl/wis_pkg.sv
package wis_pkg;

    localparam int DEF_NUM_WARPS       = 24;
    localparam int DEF_WARPS_PER_BLOCK = 8;
    localparam int DEF_PRIO_W          = 2;

    function automatic int wrap_index(input int base, input int offset, input int modulus);
        int sum;
        sum = base + offset;
        while (sum >= modulus) begin
            sum = sum - modulus;
        end
        return sum;
    endfunction

endpackage

// File: rtl/wis_resident_tracker.sv
module wis_resident_tracker #(
    parameter int NUM_WARPS       = wis_pkg::DEF_NUM_WARPS,
    parameter int WARPS_PER_BLOCK = wis_pkg::DEF_WARPS_PER_BLOCK,
    parameter int NUM_BLOCKS      = NUM_WARPS / WARPS_PER_BLOCK,
    parameter int WID_W           = $clog2(NUM_WARPS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_BLOCKS-1:0] launch_mask,
    input  logic                  retire_valid,
    input  logic [WID_W-1:0]      retire_warp,
    output logic [NUM_WARPS-1:0]  resident,
    output logic [NUM_WARPS-1:0]  retire_mask,
    output logic [NUM_BLOCKS-1:0] block_done
);

    logic [NUM_WARPS-1:0]  resident_q;
    logic [NUM_WARPS-1:0]  resident_d;
    logic [NUM_WARPS-1:0]  launch_expand;
    logic [NUM_BLOCKS-1:0] done_d;
    logic [NUM_BLOCKS-1:0] done_q;

    // One-hot decode of the retire request.
    always_comb begin
        retire_mask = '0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            if (retire_valid && (int'(retire_warp) == w)) begin
                retire_mask[w] = 1'b1;
            end
        end
    end

    // Block-to-warp expansion and completion detection, one slice per block.
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_block
        localparam int LO = b * WARPS_PER_BLOCK;

        assign launch_expand[LO +: WARPS_PER_BLOCK] = {WARPS_PER_BLOCK{launch_mask[b]}};

        always_comb begin
            done_d[b] = (|resident_q[LO +: WARPS_PER_BLOCK]) &&
                        !(|resident_d[LO +: WARPS_PER_BLOCK]);
        end
    end

    // Slots beyond the last full block are never resident.
    if (NUM_BLOCKS * WARPS_PER_BLOCK < NUM_WARPS) begin : g_tail
        assign launch_expand[NUM_WARPS-1:NUM_BLOCKS*WARPS_PER_BLOCK] = '0;
    end

    always_comb begin
        resident_d = (resident_q & ~retire_mask) | launch_expand;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resident_q <= '0;
            done_q     <= '0;
        end else begin
            resident_q <= resident_d;
            done_q     <= done_d;
        end
    end

    assign resident   = resident_q;
    assign block_done = done_q;

endmodule

// File: rtl/wis_prio_filter.sv
module wis_prio_filter #(
    parameter int NUM_WARPS = wis_pkg::DEF_NUM_WARPS,
    parameter int PRIO_W    = wis_pkg::DEF_PRIO_W
) (
    input  logic [NUM_WARPS-1:0]        eligible,
    input  logic [NUM_WARPS*PRIO_W-1:0] prio_flat,
    output logic [NUM_WARPS-1:0]        top_mask
);

    logic [PRIO_W-1:0] best;

    // Largest priority over the eligible warps.
    always_comb begin
        best = '0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            if (eligible[w] && (prio_flat[w*PRIO_W +: PRIO_W] > best)) begin
                best = prio_flat[w*PRIO_W +: PRIO_W];
            end
        end
    end

    // Eligible warps that share that largest priority.
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_sel
        assign top_mask[w] = eligible[w] && (prio_flat[w*PRIO_W +: PRIO_W] == best);
    end

endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
    parameter int NUM_WARPS = wis_pkg::DEF_NUM_WARPS,
    parameter int WID_W     = $clog2(NUM_WARPS)
) (
    input  logic [NUM_WARPS-1:0] cand_mask,
    input  logic [WID_W-1:0]     last_idx,
    output logic                 found,
    output logic [WID_W-1:0]     pick_idx
);

    // Scan upward from the warp after the last grant, wrapping at the top.
    always_comb begin
        int pos;
        found    = 1'b0;
        pick_idx = '0;
        for (int k = 1; k <= NUM_WARPS; k++) begin
            pos = wis_pkg::wrap_index(int'(last_idx), k, NUM_WARPS);
            if (!found && cand_mask[pos]) begin
                found    = 1'b1;
                pick_idx = WID_W'(pos);
            end
        end
    end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
    parameter int NUM_WARPS       = wis_pkg::DEF_NUM_WARPS,
    parameter int WARPS_PER_BLOCK = wis_pkg::DEF_WARPS_PER_BLOCK,
    parameter int PRIO_W          = wis_pkg::DEF_PRIO_W,
    parameter int NUM_BLOCKS      = NUM_WARPS / WARPS_PER_BLOCK,
    parameter int WID_W           = $clog2(NUM_WARPS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_BLOCKS-1:0]       launch_mask,
    input  logic                        retire_valid,
    input  logic [WID_W-1:0]            retire_warp,
    input  logic [NUM_WARPS-1:0]        warp_ready,
    input  logic [NUM_WARPS*PRIO_W-1:0] warp_prio,
    output logic                        grant_valid,
    output logic [WID_W-1:0]            grant_warp,
    output logic [NUM_BLOCKS-1:0]       block_done
);

    localparam logic [WID_W-1:0] LAST_RESET = WID_W'(NUM_WARPS - 1);

    logic [NUM_WARPS-1:0] resident;
    logic [NUM_WARPS-1:0] retire_mask;
    logic [NUM_WARPS-1:0] eligible;
    logic [NUM_WARPS-1:0] top_mask;
    logic                 pick_found;
    logic [WID_W-1:0]     pick_idx;
    logic [WID_W-1:0]     last_q;
    logic                 gv_q;
    logic [WID_W-1:0]     gw_q;

    wis_resident_tracker #(
        .NUM_WARPS      (NUM_WARPS),
        .WARPS_PER_BLOCK(WARPS_PER_BLOCK),
        .NUM_BLOCKS     (NUM_BLOCKS),
        .WID_W          (WID_W)
    ) u_track (
        .clk         (clk),
        .rst         (rst),
        .launch_mask (launch_mask),
        .retire_valid(retire_valid),
        .retire_warp (retire_warp),
        .resident    (resident),
        .retire_mask (retire_mask),
        .block_done  (block_done)
    );

    // A warp leaving this cycle is no longer a candidate.
    assign eligible = resident & warp_ready & ~retire_mask;

    wis_prio_filter #(
        .NUM_WARPS(NUM_WARPS),
        .PRIO_W   (PRIO_W)
    ) u_prio (
        .eligible (eligible),
        .prio_flat(warp_prio),
        .top_mask (top_mask)
    );

    wis_rr_pick #(
        .NUM_WARPS(NUM_WARPS),
        .WID_W    (WID_W)
    ) u_pick (
        .cand_mask(top_mask),
        .last_idx (last_q),
        .found    (pick_found),
        .pick_idx (pick_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gv_q   <= 1'b0;
            gw_q   <= '0;
            last_q <= LAST_RESET;
        end else begin
            gv_q <= pick_found;
            if (pick_found) begin
                gw_q   <= pick_idx;
                last_q <= pick_idx;
            end
        end
    end

    assign grant_valid = gv_q;
    assign grant_warp  = gw_q;

endmodule

// File: rtl/wis_sched_chk.sv
module wis_sched_chk #(
    parameter int NUM_WARPS       = wis_pkg::DEF_NUM_WARPS,
    parameter int WARPS_PER_BLOCK = wis_pkg::DEF_WARPS_PER_BLOCK,
    parameter int PRIO_W          = wis_pkg::DEF_PRIO_W,
    parameter int NUM_BLOCKS      = NUM_WARPS / WARPS_PER_BLOCK,
    parameter int WID_W           = $clog2(NUM_WARPS)
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        retire_valid,
    input logic [WID_W-1:0]            retire_warp,
    input logic [NUM_WARPS-1:0]        warp_ready,
    input logic [NUM_WARPS*PRIO_W-1:0] warp_prio,
    input logic [NUM_WARPS-1:0]        resident,
    input logic                        grant_valid,
    input logic [WID_W-1:0]            grant_warp,
    input logic [NUM_BLOCKS-1:0]       block_done
);

    logic [NUM_WARPS-1:0]        elig_q;
    logic [NUM_WARPS*PRIO_W-1:0] prio_q;
    logic [NUM_WARPS-1:0]        ret_oh;
    logic [PRIO_W-1:0]           max_q;

    always_comb begin
        ret_oh = '0;
        if (retire_valid && (int'(retire_warp) < NUM_WARPS)) begin
            ret_oh[retire_warp] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            elig_q <= '0;
            prio_q <= '0;
        end else begin
            elig_q <= resident & warp_ready & ~ret_oh;
            prio_q <= warp_prio;
        end
    end

    always_comb begin
        max_q = '0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            if (elig_q[w] && (prio_q[w*PRIO_W +: PRIO_W] > max_q)) begin
                max_q = prio_q[w*PRIO_W +: PRIO_W];
            end
        end
    end

    a_r4_index_range: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (int'(grant_warp) < NUM_WARPS));

    a_r3_grant_eligible: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> elig_q[grant_warp]);

    a_r7_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
        (elig_q == '0) |-> !grant_valid);

    a_r4_no_bubble: assert property (@(posedge clk) disable iff (rst)
        (elig_q != '0) |-> grant_valid);

    a_r5_top_priority: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (prio_q[grant_warp*PRIO_W +: PRIO_W] == max_q));

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_done
        a_r9_done_empty: assert property (@(posedge clk) disable iff (rst)
            block_done[b] |-> (resident[b*WARPS_PER_BLOCK +: WARPS_PER_BLOCK] == '0));
    end

endmodule

bind warp_issue_sched wis_sched_chk #(
    .NUM_WARPS      (NUM_WARPS),
    .WARPS_PER_BLOCK(WARPS_PER_BLOCK),
    .PRIO_W         (PRIO_W),
    .NUM_BLOCKS     (NUM_BLOCKS),
    .WID_W          (WID_W)
) u_sched_chk (
    .clk         (clk),
    .rst         (rst),
    .retire_valid(retire_valid),
    .retire_warp (retire_warp),
    .warp_ready  (warp_ready),
    .warp_prio   (warp_prio),
    .resident    (resident),
    .grant_valid (grant_valid),
    .grant_warp  (grant_warp),
    .block_done  (block_done)
);

// File: tb/warp_issue_sched_bench.sv
module warp_issue_sched_bench;

    localparam int NW  = 24;
    localparam int WPB = 8;
    localparam int PW  = 2;
    localparam int NB  = NW / WPB;
    localparam int IW  = $clog2(NW);

    logic             clk = 1'b0;
    logic             rst;
    logic [NB-1:0]    launch_mask;
    logic             retire_valid;
    logic [IW-1:0]    retire_warp;
    logic [NW-1:0]    warp_ready;
    logic [NW*PW-1:0] warp_prio;
    logic             grant_valid;
    logic [IW-1:0]    grant_warp;
    logic [NB-1:0]    block_done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    warp_issue_sched #(
        .NUM_WARPS(NW), .WARPS_PER_BLOCK(WPB), .PRIO_W(PW)
    ) u_warp_issue_sched (
        .clk(clk), .rst(rst), .launch_mask(launch_mask),
        .retire_valid(retire_valid), .retire_warp(retire_warp),
        .warp_ready(warp_ready), .warp_prio(warp_prio),
        .grant_valid(grant_valid), .grant_warp(grant_warp),
        .block_done(block_done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_grant(input string req, input int warp);
        check({req, " valid"}, int'(grant_valid), 1);
        check({req, " warp"}, int'(grant_warp), warp);
    endtask

    task automatic set_prio(input int w, input int val);
        warp_prio[w*PW +: PW] = PW'(val);
    endtask

    task automatic t_reset();
        rst = 1'b1; launch_mask = '0; retire_valid = 1'b0; retire_warp = '0;
        warp_ready = '0; warp_prio = '0;
        repeat (3) step();
        check("R1 reset grant", int'(grant_valid), 0);
        check("R1 reset done", int'(block_done), 0);
        rst = 1'b0;
        step();
        check("R1 post-reset grant", int'(grant_valid), 0);
    endtask

    task automatic t_nothing_resident();
        warp_ready = '1;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R3 ready but not resident", int'(grant_valid), 0);
        end
    endtask

    task automatic t_launch_rotate();
        launch_mask = 3'b001;
        step();
        check("R2 no grant in launch cycle", int'(grant_valid), 0);
        launch_mask = '0;
        for (int i = 0; i < 9; i++) begin
            step();
            expect_grant("R6 rotation from reset pointer (R1 R4)", i % WPB);
        end
    endtask

    task automatic t_ready_subset();
        warp_ready = '0;
        warp_ready[3] = 1'b1; warp_ready[5] = 1'b1; warp_ready[12] = 1'b1;
        step(); expect_grant("R3 ready subset", 3);
        step(); expect_grant("R3 ready subset", 5);
        step(); expect_grant("R3 ready subset", 3);
        step(); expect_grant("R3 ready subset", 5);
    endtask

    task automatic t_priority();
        warp_ready = '1;
        set_prio(6, 3); set_prio(2, 2);
        for (int i = 0; i < 3; i++) begin
            step(); expect_grant("R5 highest priority", 6);
        end
        warp_ready[6] = 1'b0;
        step(); expect_grant("R5 next priority level", 2);
        warp_ready = '1; warp_prio = '0;
        set_prio(2, 1); set_prio(7, 1);
        step(); expect_grant("R6 tie rotates", 7);
        step(); expect_grant("R6 tie rotates", 2);
        step(); expect_grant("R6 tie rotates", 7);
        warp_prio = '0;
    endtask

    task automatic t_idle();
        warp_ready = '0;
        step(); check("R7 idle no grant", int'(grant_valid), 0);
        step(); check("R7 idle no grant", int'(grant_valid), 0);
        warp_ready = '1;
        step(); expect_grant("R7 pointer held over idle", 0);
    endtask

    task automatic t_retire_block();
        int order[7] = '{0, 3, 4, 5, 6, 2, 7};
        warp_ready = '1;
        retire_valid = 1'b1; retire_warp = IW'(1);
        step(); expect_grant("R3 retiring warp skipped", 2);
        retire_valid = 1'b0;
        step(); expect_grant("R8 retired warp stays out", 3);
        retire_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            retire_warp = IW'(order[i]);
            step();
            check("R9 no done while warps remain", int'(block_done), 0);
        end
        retire_warp = IW'(order[6]);
        step();
        check("R9 done pulse block 0", int'(block_done), 1);
        retire_valid = 1'b0;
        step();
        check("R9 done lasts one cycle", int'(block_done), 0);
        check("R8 empty block issues nothing", int'(grant_valid), 0);
    endtask

    task automatic t_block_mapping();
        warp_ready = '0;
        warp_ready[17] = 1'b1; warp_ready[9] = 1'b1;
        launch_mask = 3'b100;
        step();
        check("R2 launch cycle", int'(grant_valid), 0);
        launch_mask = '0;
        step(); expect_grant("R2 block 2 holds warp 17", 17);
        step(); expect_grant("R2 block 1 warp 9 absent", 17);
        retire_valid = 1'b1; retire_warp = IW'(9);
        step();
        check("R8 absent retire no done", int'(block_done), 0);
        expect_grant("R8 absent retire no effect", 17);
        retire_warp = IW'(17);
        step();
        check("R9 partial retire no done", int'(block_done), 0);
        check("R3 retiring warp not granted", int'(grant_valid), 0);
        retire_valid = 1'b0;
        step();
        check("R8 warp 17 gone", int'(grant_valid), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_nothing_resident();
        t_launch_rotate();
        t_ready_subset();
        t_priority();
        t_idle();
        t_retire_block();
        t_block_mapping();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule